// File: doc/BRIEF.md
# Burst Bus Target Interface

This block is the responding side of a synchronous shared bus where address and data travel on the same lines. A transaction opens when the initiator pulls the active-low transaction line low and presents a command and a word address. If the address falls inside the target's window and the command is a read or a write, the target claims the transaction and moves one data word on each rising edge where both the initiator-ready and target-ready lines are low. The burst has no fixed length. The initiator marks its final word by releasing the transaction line, and the target keeps an internal word offset that advances after every completed transfer.

The back end is a small register file inside the block. An external wait input stands for a slow back end: while it is high the target withholds its ready signal. If the back end stalls for too long, the target asks the initiator to retry. The target also disconnects a burst that would run past the last word of its window. Read data leaves the target only after one idle turnaround cycle, so that the address driver and the data driver never overlap.

Top module: `bt_target`

## Requirements
- R1: While reset is active and on the first cycle after it, claim_n, tgt_rdy_n and tgt_halt_n are high and ad_oe is low.
- R2: When the target is idle and samples txn_n low, it claims the transaction only if ad_in lies in [BASE, BASE+DEPTH) and the command is a read or a write. claim_n then goes low from the next cycle. Otherwise claim_n stays high for the whole transaction and no register changes.
- R3: The command code 2'b01 means read and 2'b10 means write. Any other code on cmd is not claimed, even inside the window.
- R4: A write stores ad_in into the register at the current offset on each rising edge where both tgt_rdy_n and init_rdy_n are low, and only on such edges.
- R5: A claimed read spends its first claimed cycle as a turnaround, with ad_oe low and tgt_rdy_n high, and drives data from the second claimed cycle onward. A claimed write may assert tgt_rdy_n in its first claimed cycle.
- R6: The first data word uses offset ad_in-BASE from the address phase. The offset rises by one after each completed transfer and holds during wait cycles. On a read, ad_out carries the register at the current offset whenever ad_oe is high.
- R7: A transfer on an edge where txn_n is high is the last one. In the next cycle claim_n is high and ad_oe is low.
- R8: While be_wait is high, tgt_rdy_n is high.
- R9: While the current offset is the last word of the window and the target is ready, tgt_halt_n is low together with tgt_rdy_n. If txn_n is still low after that transfer, the target keeps tgt_halt_n low and tgt_rdy_n high until it samples txn_n high. No word beyond the window moves.
- R10: If be_wait stays high for RETRY_LIMIT consecutive data-phase cycles, the target asserts tgt_halt_n without tgt_rdy_n, which asks the initiator to retry, and it returns to idle after it samples txn_n high.
- R11: tgt_rdy_n and ad_oe are low only while claim_n is low, and ad_oe is high only in read transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| txn_n | input | 1 | Active low while the initiator wants more transfers; goes high for the final word |
| cmd | input | 2 | Command during the address phase: 01 read, 10 write |
| ad_in | input | DW | Address in the address phase, write data in data phases |
| init_rdy_n | input | 1 | Active-low initiator ready |
| be_wait | input | 1 | Back-end stall request; inserts wait states |
| ad_out | output | DW | Read data, zero when not driven |
| ad_oe | output | 1 | High while the target drives ad_out |
| tgt_rdy_n | output | 1 | Active-low target ready |
| tgt_halt_n | output | 1 | Active-low stop: disconnect at window end or retry |
| claim_n | output | 1 | Active low while the target owns the transaction |

## Verification
The target reacts one edge after the address phase. claim_n falls in the next cycle. A write can be ready in that same cycle, while the first read word appears one cycle later, after the turnaround. A transfer on an edge with txn_n high frees the bus in the following cycle. A read that the back end stalls shows tgt_halt_n after RETRY_LIMIT+1 claimed cycles (the turnaround plus RETRY_LIMIT data cycles). The bench changes inputs one nanosecond after each rising edge and reads every output at the falling edge, so each check sees the settled value for the cycle it counts to. A monitor pairs every read transfer with the next word queued by the driver.

// File: rtl/bt_pkg.sv
// Shared types for the burst target: controller states and command codes.
package bt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,  // waiting for an address phase
        ST_SKIP,  // transaction belongs to someone else
        ST_TURN,  // read turnaround, bus left undriven
        ST_DATA,  // data phases
        ST_HALT   // stop asserted, waiting for the initiator to let go
    } bt_state_e;

    localparam logic [1:0] CMD_RD = 2'b01;
    localparam logic [1:0] CMD_WR = 2'b10;
endpackage

// File: rtl/bt_window.sv
// Address window decoder.
// Reports whether a word address lies in [BASE, BASE+DEPTH) and gives the
// offset into the window. Assumes DEPTH >= 2.
module bt_window #(
    parameter int DW = 32,
    parameter logic [DW-1:0] BASE = 'h40,
    parameter int DEPTH = 16,
    localparam int OW = $clog2(DEPTH)
) (
    input  logic [DW-1:0] addr_i,
    output logic          hit_o,
    output logic [OW-1:0] off_o
);
    localparam logic [DW:0] LIMIT = {1'b0, BASE} + (DW+1)'(DEPTH);

    // Range compare, with one guard bit so the window end cannot overflow.
    always_comb begin
        hit_o = ({1'b0, addr_i} >= {1'b0, BASE}) && ({1'b0, addr_i} < LIMIT);
        off_o = OW'(addr_i - BASE);
    end
endmodule

// File: rtl/bt_regfile.sv
// Register-file back end with one write port and one combinational read port.
// Every word resets to zero. Assumes wr_idx and rd_idx stay below DEPTH.
module bt_regfile #(
    parameter int DW = 32,
    parameter int DEPTH = 16,
    localparam int OW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [OW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [OW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] word_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        // One word: cleared on reset, loaded when the write port selects it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q[g] <= '0;
            else if (wr_en && wr_idx == OW'(g))
                word_q[g] <= wr_data;
        end
    end

    // Read port: the word at the current offset.
    assign rd_data = word_q[rd_idx];
endmodule

// File: rtl/bt_retry.sv
// Stall counter for retry.
// Counts consecutive stalled data cycles. expire_o is high in the cycle that
// completes LIMIT of them. Assumes the owner leaves the data phase on expiry.
module bt_retry #(
    parameter int LIMIT = 8,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stall_i,
    output logic expire_o
);
    logic [CW-1:0] cnt_q;

    // Run length of the current stall, cleared as soon as it breaks.
    always_ff @(posedge clk) begin
        if (!rst_n || !stall_i)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign expire_o = stall_i && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/bt_target.sv
// Burst bus target.
// Decodes an address phase on a multiplexed address/data bus, claims it when
// it hits the window, then moves one word per edge with both readies low.
// Reads get one turnaround cycle first. Disconnects at the window end and asks
// for a retry after RETRY_LIMIT stalled cycles.
// Assumes the initiator keeps txn_n low until its final word and releases it
// once stop is seen.
module bt_target
    import bt_pkg::*;
#(
    parameter int DW = 32,
    parameter logic [DW-1:0] BASE = 'h40,
    parameter int DEPTH = 16,
    parameter int RETRY_LIMIT = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          txn_n,
    input  logic [1:0]    cmd,
    input  logic [DW-1:0] ad_in,
    input  logic          init_rdy_n,
    input  logic          be_wait,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe,
    output logic          tgt_rdy_n,
    output logic          tgt_halt_n,
    output logic          claim_n
);
    localparam int OW = $clog2(DEPTH);

    bt_state_e     state_q, state_d;
    logic [OW-1:0] off_q;
    logic          rd_q;
    logic          win_hit;
    logic [OW-1:0] win_off;
    logic [DW-1:0] rd_word;
    logic          cmd_ok, addr_phase, in_data, tgt_ready, xfer, at_end, stall, expire;

    bt_window #(.DW(DW), .BASE(BASE), .DEPTH(DEPTH)) u_window (
        .addr_i (ad_in),
        .hit_o  (win_hit),
        .off_o  (win_off)
    );

    bt_regfile #(.DW(DW), .DEPTH(DEPTH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (xfer && !rd_q),
        .wr_idx  (off_q),
        .wr_data (ad_in),
        .rd_idx  (off_q),
        .rd_data (rd_word)
    );

    bt_retry #(.LIMIT(RETRY_LIMIT)) u_retry (
        .clk      (clk),
        .rst_n    (rst_n),
        .stall_i  (stall),
        .expire_o (expire)
    );

    // Handshake terms for the current cycle.
    always_comb begin
        cmd_ok     = (cmd == CMD_RD) || (cmd == CMD_WR);
        addr_phase = (state_q == ST_IDLE) && !txn_n;
        in_data    = (state_q == ST_DATA);
        tgt_ready  = in_data && !be_wait;
        xfer       = tgt_ready && !init_rdy_n;
        at_end     = (off_q == OW'(DEPTH - 1));
        stall      = in_data && be_wait;
    end

    // Next-state selection for the transaction controller.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (!txn_n)
                         state_d = !(win_hit && cmd_ok) ? ST_SKIP :
                                   (cmd == CMD_RD)      ? ST_TURN : ST_DATA;
            ST_SKIP: if (txn_n) state_d = ST_IDLE;
            ST_TURN: state_d = ST_DATA;
            ST_DATA: begin
                if (xfer) begin
                    if (txn_n)       state_d = ST_IDLE;
                    else if (at_end) state_d = ST_HALT;
                end else if (expire) begin
                    state_d = ST_HALT;
                end
            end
            ST_HALT: if (txn_n) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State, burst offset and direction registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            off_q   <= '0;
            rd_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (addr_phase) begin
                off_q <= win_off;
                rd_q  <= (cmd == CMD_RD);
            end else if (xfer) begin
                off_q <= off_q + 1'b1;
            end
        end
    end

    // Bus-side outputs.
    always_comb begin
        tgt_rdy_n  = !tgt_ready;
        tgt_halt_n = !((tgt_ready && at_end) || state_q == ST_HALT);
        claim_n    = !(state_q inside {ST_TURN, ST_DATA, ST_HALT});
        ad_oe      = in_data && rd_q;
        ad_out     = ad_oe ? rd_word : '0;
    end
endmodule

// File: rtl/bt_target_chk.sv
// Protocol checker for bt_target, attached with bind. It only observes ports.
module bt_target_chk #(
    parameter int RETRY_LIMIT = 8,
    localparam int CW = $clog2(RETRY_LIMIT + 3)
) (
    input logic clk,
    input logic rst_n,
    input logic txn_n,
    input logic init_rdy_n,
    input logic be_wait,
    input logic ad_oe,
    input logic tgt_rdy_n,
    input logic tgt_halt_n,
    input logic claim_n
);
    logic [CW-1:0] wait_run;

    // Length of the current run of claimed, stalled cycles without stop.
    always_ff @(posedge clk) begin
        if (!rst_n || claim_n || !tgt_rdy_n || !tgt_halt_n || !be_wait)
            wait_run <= '0;
        else
            wait_run <= wait_run + 1'b1;
    end

    AST_RDY_IN_CLAIM:    assert property (@(posedge clk) disable iff (!rst_n) !tgt_rdy_n |-> !claim_n); // R11
    AST_OE_IN_CLAIM:     assert property (@(posedge clk) disable iff (!rst_n) ad_oe |-> !claim_n); // R11
    AST_WAIT_HOLDS_RDY:  assert property (@(posedge clk) disable iff (!rst_n) be_wait |-> tgt_rdy_n); // R8
    AST_CLAIM_AFTER_ADR: assert property (@(posedge clk) disable iff (!rst_n) $fell(claim_n) |-> $past(!txn_n)); // R2
    AST_TURN_QUIET:      assert property (@(posedge clk) disable iff (!rst_n) $fell(claim_n) |-> !ad_oe); // R5
    AST_LAST_RELEASES:   assert property (@(posedge clk) disable iff (!rst_n)
                             (!tgt_rdy_n && !init_rdy_n && txn_n) |=> (claim_n && !ad_oe)); // R7
    AST_HALT_HOLDS:      assert property (@(posedge clk) disable iff (!rst_n)
                             (!tgt_halt_n && tgt_rdy_n && !txn_n) |=> !tgt_halt_n); // R9
    AST_RETRY_BOUND:     assert property (@(posedge clk) disable iff (!rst_n)
                             wait_run <= CW'(RETRY_LIMIT + 1)); // R10
endmodule

bind bt_target bt_target_chk #(.RETRY_LIMIT(RETRY_LIMIT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .txn_n      (txn_n),
    .init_rdy_n (init_rdy_n),
    .be_wait    (be_wait),
    .ad_oe      (ad_oe),
    .tgt_rdy_n  (tgt_rdy_n),
    .tgt_halt_n (tgt_halt_n),
    .claim_n    (claim_n)
);

// File: tb/sim_bt_target.sv
// Scoreboard bench for bt_target. The burst driver queues the read words it
// expects; the monitor pops one for every read transfer it sees.
module sim_bt_target;
    localparam int          DW    = 32;
    localparam logic [31:0] BASE  = 32'h40;
    localparam int          DEPTH = 16;
    localparam int          LIM   = 8;
    localparam logic [1:0]  RD    = 2'b01;
    localparam logic [1:0]  WR    = 2'b10;

    logic clk = 0, rst_n = 0, txn_n = 1, init_rdy_n = 1, be_wait = 0;
    logic [1:0]  cmd = 2'b00;
    logic [31:0] ad_in = '0;
    logic [31:0] ad_out;
    logic ad_oe, tgt_rdy_n, tgt_halt_n, claim_n;

    int checks = 0, fails = 0;
    logic [31:0] model [DEPTH];
    logic [31:0] exp_q [$];
    bit wpat = 0, ipat = 0;

    always #2 clk = ~clk;

    bt_target #(.DW(DW), .BASE(BASE), .DEPTH(DEPTH), .RETRY_LIMIT(LIM)) u0 (
        .clk(clk), .rst_n(rst_n), .txn_n(txn_n), .cmd(cmd), .ad_in(ad_in),
        .init_rdy_n(init_rdy_n), .be_wait(be_wait), .ad_out(ad_out), .ad_oe(ad_oe),
        .tgt_rdy_n(tgt_rdy_n), .tgt_halt_n(tgt_halt_n), .claim_n(claim_n)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Monitor: each read transfer must carry the next queued word (R6).
    always @(negedge clk) begin
        logic [31:0] e;
        if (rst_n && ad_oe && !tgt_rdy_n && !init_rdy_n) begin
            if (exp_q.size() == 0)
                check(0, "R6 read word not expected", ad_out, 0);
            else begin
                e = exp_q.pop_front();
                check(ad_out === e, "R6 read data", ad_out, e);
            end
        end
    end

    // Initiator for one burst of n words; got returns the number that moved.
    task automatic burst(input logic [1:0] c, input logic [31:0] start, input int n,
                         input logic [31:0] seed, output int got);
        int  i = 0, guard = 0;
        bit  xf, hnd, done = 0;
        @(posedge clk); #1;
        txn_n = 0; cmd = c; ad_in = start; init_rdy_n = 1;
        @(posedge clk); #1;
        cmd = 2'b00; txn_n = (n == 1); ad_in = seed;
        init_rdy_n = ipat; be_wait = 0;
        while (!done && guard < 200) begin
            @(negedge clk);
            xf  = !tgt_rdy_n && !init_rdy_n;
            hnd = !tgt_halt_n && tgt_rdy_n;
            @(posedge clk); #1;
            guard++;
            if (xf) begin
                if (c == WR) model[start - BASE + i] = seed + i;
                i++;
                if (txn_n) done = 1;
                else begin
                    ad_in = seed + i;
                    if (i == n - 1) txn_n = 1;
                end
            end else if (hnd) begin
                txn_n = 1; init_rdy_n = 1; done = 1;
            end
            if (!done) begin
                be_wait    = wpat && (guard % 3 == 1);
                init_rdy_n = ipat && (guard % 2 == 0);
            end
        end
        check(done, "R4 burst completes", guard, 0);
        txn_n = 1; init_rdy_n = 1; be_wait = 0;
        @(posedge clk); #1;
        got = i;
    endtask

    // Reads n words from start and expects exp_n of them to move.
    task automatic read_burst(input logic [31:0] start, input int n, input int exp_n, input string req);
        int got;
        for (int k = 0; k < exp_n; k++) exp_q.push_back(model[start - BASE + k]);
        burst(RD, start, n, 0, got);
        check(got == exp_n, req, got, exp_n);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
        exp_q.delete();
    endtask

    // Address phase that must not be claimed; data is offered anyway.
    task automatic foreign(input logic [1:0] c, input logic [31:0] addr, input string req);
        @(posedge clk); #1;
        txn_n = 0; cmd = c; ad_in = addr;
        @(posedge clk); #1;
        cmd = 2'b00; ad_in = 32'hDEAD_BEEF; init_rdy_n = 0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(claim_n === 1'b1, req, claim_n, 1);
            check(tgt_rdy_n === 1'b1, "R11 no ready unclaimed", tgt_rdy_n, 1);
            @(posedge clk); #1;
        end
        txn_n = 1; init_rdy_n = 1;
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "ALL watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int got, cnt;
        for (int k = 0; k < DEPTH; k++) model[k] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(claim_n === 1'b1 && tgt_rdy_n === 1'b1, "R1 reset claim/ready", {claim_n, tgt_rdy_n}, 2'b11);
        check(tgt_halt_n === 1'b1 && ad_oe === 1'b0, "R1 reset halt/oe", {tgt_halt_n, ad_oe}, 2'b10);
        @(posedge clk); #1; rst_n = 1;
        @(negedge clk);
        check(claim_n === 1'b1 && ad_oe === 1'b0, "R1 after reset", {claim_n, ad_oe}, 2'b10);

        // Read phase timing: turnaround, then data, then release (R5, R7).
        @(posedge clk); #1; txn_n = 0; cmd = RD; ad_in = BASE + 2;
        @(posedge clk); #1; cmd = 2'b00; txn_n = 1; init_rdy_n = 1;
        @(negedge clk);
        check(claim_n === 0 && ad_oe === 0 && tgt_rdy_n === 1, "R5 turnaround cycle",
              {claim_n, ad_oe, tgt_rdy_n}, 3'b001);
        exp_q.push_back(model[2]);
        @(posedge clk); #1; init_rdy_n = 0;
        @(negedge clk);
        check(ad_oe === 1 && tgt_rdy_n === 0, "R5 read data cycle", {ad_oe, tgt_rdy_n}, 2'b10);
        @(posedge clk); #1; init_rdy_n = 1;
        @(negedge clk);
        check(claim_n === 1 && ad_oe === 0, "R7 release after last", {claim_n, ad_oe}, 2'b10);

        // Write phase timing: ready in the first claimed cycle (R5).
        @(posedge clk); #1; txn_n = 0; cmd = WR; ad_in = BASE + 12;
        @(posedge clk); #1; cmd = 2'b00; txn_n = 1; ad_in = 32'h1234_5678; init_rdy_n = 1;
        @(negedge clk);
        check(claim_n === 0 && tgt_rdy_n === 0, "R5 write ready at once", {claim_n, tgt_rdy_n}, 2'b00);
        @(posedge clk); #1; init_rdy_n = 0;
        @(posedge clk); #1; init_rdy_n = 1;
        model[12] = 32'h1234_5678;
        @(negedge clk);
        check(claim_n === 1, "R7 write release", claim_n, 1);

        burst(WR, BASE, 6, 32'hA000, got);
        check(got == 6, "R4 plain write burst", got, 6);
        wpat = 1; ipat = 1;
        burst(WR, BASE + 6, 4, 32'hB000, got);
        check(got == 4, "R8 write burst with waits", got, 4);
        wpat = 0; ipat = 0;
        burst(WR, BASE + 10, 1, 32'hE000, got);
        check(got == 1, "R7 single word write", got, 1);
        burst(WR, BASE + DEPTH - 2, 5, 32'hC000, got);
        check(got == 2, "R9 write disconnect at window end", got, 2);

        foreign(WR, BASE + DEPTH, "R2 above window");
        foreign(WR, BASE - 1, "R2 below window");
        foreign(2'b11, BASE, "R3 bad command");

        read_burst(BASE, DEPTH, DEPTH, "R6 full window read");
        wpat = 1; ipat = 1;
        read_burst(BASE + 3, 5, 5, "R8 read with waits");
        wpat = 0; ipat = 0;
        read_burst(BASE + DEPTH - 3, 6, 3, "R9 read disconnect");

        // Retry after LIM stalled data cycles (R10).
        @(posedge clk); #1; txn_n = 0; cmd = RD; ad_in = BASE; be_wait = 1;
        @(posedge clk); #1; cmd = 2'b00; init_rdy_n = 0;
        cnt = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (tgt_halt_n === 1'b0) break;
            cnt++;
        end
        check(cnt == LIM + 1, "R10 retry timing", cnt, LIM + 1);
        check(tgt_rdy_n === 1'b1, "R10 retry carries no data", tgt_rdy_n, 1);
        @(posedge clk); #1; txn_n = 1; init_rdy_n = 1; be_wait = 0;
        @(negedge clk);
        check(!tgt_halt_n === 1'b1, "R10 halt held until release seen", tgt_halt_n, 0);
        @(posedge clk); #1;
        @(negedge clk);
        check(claim_n === 1 && tgt_halt_n === 1, "R10 back to idle", {claim_n, tgt_halt_n}, 2'b11);

        read_burst(BASE + 10, 3, 3, "R6 read after retry");
        finish_run();
    end
endmodule